// File: doc/BRIEF.md
# SMI Feature Handshake and APM Port Dispatcher

This block runs the handshake in which guest firmware asks the platform for a set of system-management-interrupt features, and it decides where an SMI goes when software writes the APM control port. A fixed host feature mask says which features the platform offers. The guest builds a 64-bit request one byte at a time, using byte lanes in little-endian order. It then writes the acknowledge register to ask for validation. The block accepts the request only if every bit is offered by the host and the combination is legal. It then copies the request into the agreed mask and locks it until reset.

Writes to the APM control port are decoded in one of three ways. The two ACPI command codes only produce a one-cycle enable or disable pulse. Any other code raises SMI, if the APMC enable bit of the SMI enable register allows it. The SMI goes to every CPU when the broadcast feature was agreed, and otherwise only to the CPU that made the write. CPUs are seen only as a per-CPU request vector.

Top module: `smi_feature_gate`

## Requirements
- R1: After reset the requested mask, the agreed mask, the accepted flag, both ACPI pulses and the SMI vector are all zero.
- R2: A request write with byte index i (0..7) replaces bits [8i+7:8i] of the requested mask and leaves the other bits unchanged. The new value can be read on the next cycle.
- R3: An acknowledge write while not yet accepted, with a legal request, sets the accepted flag and loads the agreed mask with the requested mask on the next cycle.
- R4: A request that has any bit outside the host mask is refused: the accepted flag and the agreed mask stay zero. A later legal request can still succeed.
- R5: The feature bits are broadcast = bit 0, CPU hotplug = bit 1 and CPU hot-unplug = bit 2. A request with bit 1 or bit 2 set and bit 0 clear is refused.
- R6: Once accepted, the flag stays set and the agreed mask cannot change until reset, whatever later request or acknowledge writes occur.
- R7: An APM write of 0x02 pulses acpi_on for one cycle, and a write of 0x03 pulses acpi_off for one cycle. Neither raises any SMI.
- R8: An APM write of any other value raises no SMI when apmc_en is 0.
- R9: An APM write of any other value with apmc_en = 1 drives smi_req to all ones for one cycle if agreed bit 0 is set. Otherwise it sets only bit apm_cpu of smi_req for one cycle.
- R10: The default host mask offers broadcast and hotplug (0x3) but not hot-unplug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write one byte of the requested mask |
| req_idx | input | 3 | Byte lane of the request write |
| req_byte | input | 8 | Data of the request write |
| ack_wr | input | 1 | Write to the acknowledge register, which triggers validation |
| apm_wr | input | 1 | Write to the APM control port |
| apm_val | input | 8 | Value written to the APM port |
| apm_cpu | input | 2 | Index of the CPU doing the APM write |
| apmc_en | input | 1 | APMC enable bit of the SMI enable register |
| req_mask | output | 64 | Current requested mask |
| feat_ok | output | 1 | Request accepted and locked |
| agreed_mask | output | 64 | Locked agreed mask |
| acpi_on | output | 1 | One-cycle ACPI enable pulse |
| acpi_off | output | 1 | One-cycle ACPI disable pulse |
| smi_req | output | 4 | Per-CPU SMI request pulse |

## Verification
The hardest state to reach is a locked handshake that then sees a different, also legal request: the agreed mask must not follow it. The bench first lets a request be refused, then fixes it and has it accepted. It then rewrites the request and acknowledges again. For each outcome (unicast and broadcast) it sweeps every APM value against both enable settings and every writing CPU.

// File: rtl/smi_feature_gate.sv
module smi_feature_gate #(
  parameter int          NCPU      = 4,
  parameter int          CPU_W     = $clog2(NCPU),
  parameter int          FEAT_W    = 64,
  parameter logic [63:0] HOST_FEAT = 64'h3,
  parameter logic [7:0]  CMD_ON    = 8'h02,
  parameter logic [7:0]  CMD_OFF   = 8'h03,
  parameter int          B_BCAST   = 0,
  parameter int          B_HP      = 1,
  parameter int          B_HUP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [2:0]        req_idx,
  input  logic [7:0]        req_byte,
  input  logic              ack_wr,
  input  logic              apm_wr,
  input  logic [7:0]        apm_val,
  input  logic [CPU_W-1:0]  apm_cpu,
  input  logic              apmc_en,
  output logic [FEAT_W-1:0] req_mask,
  output logic              feat_ok,
  output logic [FEAT_W-1:0] agreed_mask,
  output logic              acpi_on,
  output logic              acpi_off,
  output logic [NCPU-1:0]   smi_req
);
  localparam logic [FEAT_W-1:0] HOST = HOST_FEAT[FEAT_W-1:0];

  logic legal, is_cmd, fire;
  logic [NCPU-1:0] target;

  assign legal  = ((req_mask & ~HOST) == '0) &&
                  !((req_mask[B_HP] || req_mask[B_HUP]) && !req_mask[B_BCAST]);
  assign is_cmd = (apm_val == CMD_ON) || (apm_val == CMD_OFF);
  assign fire   = apm_wr && !is_cmd && apmc_en;
  assign target = agreed_mask[B_BCAST] ? {NCPU{1'b1}} : (NCPU'(1) << apm_cpu);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_mask <= '0;
    end else if (req_wr) begin
      req_mask[8*req_idx +: 8] <= req_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_ok     <= 1'b0;
      agreed_mask <= '0;
    end else if (ack_wr && !feat_ok && legal) begin
      feat_ok     <= 1'b1;
      agreed_mask <= req_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acpi_on  <= 1'b0;
      acpi_off <= 1'b0;
      smi_req  <= '0;
    end else begin
      acpi_on  <= apm_wr && (apm_val == CMD_ON);
      acpi_off <= apm_wr && (apm_val == CMD_OFF);
      smi_req  <= fire ? target : '0;
    end
  end

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |=> feat_ok && $stable(agreed_mask));
  p_host_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (agreed_mask & ~HOST) == '0);
  p_hotplug_needs_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (agreed_mask[B_HP] || agreed_mask[B_HUP]) |-> agreed_mask[B_BCAST]);
  p_accept_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && !feat_ok && legal |=> feat_ok && agreed_mask == $past(req_mask));
  p_cmd_no_smi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_on || acpi_off) |-> smi_req == '0);
  p_smi_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req != '0 |-> ($countones(smi_req) == 1 || &smi_req));
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apm_wr && !apmc_en |=> smi_req == '0);
endmodule

// File: tb/tb_smi_feature_gate.sv
module tb_smi_feature_gate;
  logic clk = 0, rst_n = 0;
  logic req_wr = 0, ack_wr = 0, apm_wr = 0, apmc_en = 0;
  logic [2:0] req_idx = 0;
  logic [7:0] req_byte = 0, apm_val = 0;
  logic [1:0] apm_cpu = 0;
  logic [63:0] req_mask, agreed_mask;
  logic feat_ok, acpi_on, acpi_off;
  logic [3:0] smi_req;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  smi_feature_gate dut (.*);

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wbyte(int i, logic [7:0] b);
    @(negedge clk); req_wr = 1; req_idx = 3'(i); req_byte = b;
    @(negedge clk); req_wr = 0;
  endtask

  task automatic wmask(logic [63:0] m);
    for (int k = 7; k >= 0; k--) wbyte(k, m[8*k +: 8]);
  endtask

  task automatic ack();
    @(negedge clk); ack_wr = 1;
    @(negedge clk); ack_wr = 0;
  endtask

  function automatic bit legal(logic [63:0] v);
    return ((v & ~64'h3) == 0) && !((v[1] || v[2]) && !v[0]);
  endfunction

  initial begin
    logic [63:0] vecs [11];
    for (int i = 0; i < 8; i++) vecs[i] = 64'(i);
    vecs[8] = 64'h100; vecs[9] = 64'h8000_0000_0000_0001; vecs[10] = 64'h1_0000_0003;

    do_reset();
    @(negedge clk);
    chk("R1 req", req_mask, 0); chk("R1 ok", feat_ok, 0);
    chk("R1 agreed", agreed_mask, 0);
    chk("R1 pulses", {acpi_on, acpi_off, smi_req}, 0);

    // R2 byte lanes
    wbyte(3, 8'hA5);
    chk("R2 lane3", req_mask, 64'h0000_0000_A500_0000);
    wbyte(7, 8'h5A);
    chk("R2 lane7", req_mask, 64'h5A00_0000_A500_0000);
    wbyte(3, 8'h00);
    chk("R2 lane3 clear", req_mask, 64'h5A00_0000_0000_0000);

    // R3/R4/R5/R10 sweep
    foreach (vecs[n]) begin
      do_reset();
      wmask(vecs[n]);
      chk("R2 full", req_mask, vecs[n]);
      ack();
      chk(legal(vecs[n]) ? "R3 ok" : "R4/R5 ok", feat_ok, legal(vecs[n]));
      chk(legal(vecs[n]) ? "R3 agreed" : "R4/R5 agreed", agreed_mask,
          legal(vecs[n]) ? vecs[n] : 64'h0);
    end
    // R10 hot-unplug not offered even with broadcast
    do_reset(); wmask(64'h5); ack();
    chk("R10 unplug refused", feat_ok, 0);

    // R4 retry after refusal, then R6 lock
    do_reset(); wmask(64'h2); ack();
    chk("R5 refused", feat_ok, 0);
    wmask(64'h1); ack();
    chk("R4 retry ok", feat_ok, 1); chk("R4 retry agreed", agreed_mask, 1);
    wmask(64'h3); ack();
    chk("R6 ok held", feat_ok, 1); chk("R6 agreed locked", agreed_mask, 1);
    wmask(64'hFF00); ack();
    chk("R6 agreed locked 2", agreed_mask, 1);

    // APM sweep for unicast (agreed 0) and broadcast (agreed 1)
    for (int mode = 0; mode < 2; mode++) begin
      do_reset();
      if (mode == 1) begin wmask(64'h1); ack(); end
      for (int a = 0; a < 256; a++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 4; c++) begin
            logic [3:0] es;
            @(negedge clk);
            apm_wr = 1; apm_val = 8'(a); apmc_en = e[0]; apm_cpu = 2'(c);
            @(negedge clk);
            apm_wr = 0;
            es = (a == 2 || a == 3 || e == 0) ? 4'h0 :
                 (mode == 1 ? 4'hF : 4'(1 << c));
            chk("R7 on", acpi_on, a == 2);
            chk("R7 off", acpi_off, a == 3);
            chk(e == 0 ? "R8 smi" : "R9 smi", smi_req, es);
            @(negedge clk);
            chk("R7/R9 one cycle", {acpi_on, acpi_off, smi_req}, 0);
          end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule